// File: doc/BRIEF.md
# Power-On Reset Sequencer with Boot Strap Capture

This block decides when the main power-on reset, the always-on domain reset and a peripheral reset output may be released. The main reset is held while the supply-stable flag, the oscillator-valid flag or the external warm reset request says the chip is not ready. It is released only after all three have stayed good for a fixed number of coarse time units. One unit is a fixed number of reference-clock cycles. The always-on reset follows its own supply and slow-clock flags and is timed in milliseconds. The peripheral reset follows the main reset after a further millisecond delay.

The same block also takes in the 16 boot strap pins. It checks that they were steady for a setup window before the main reset rose and that they stayed steady through a hold window after it. At the end of the hold window it latches the pin value and signals that the word is ready with a single-cycle pulse. Every delay timer starts again from zero as soon as its qualifying condition drops. A short glitch on a flag therefore always costs the full delay again.

Top module: `por_seq_ctrl`

## Requirements
- R1: Define `main_ok` as the AND of `rails_ok`, `osc_ok` and `warm_rst_n`. `por_n` goes high at the clock edge where `main_ok` has been sampled high on MAIN_P×PRESCALE+1 consecutive edges. It falls at the first edge where `main_ok` is sampled low.
- R2: The coarse time unit is PRESCALE reference-clock cycles. Its counter starts from zero whenever the condition being timed is false.
- R3: `boot_ok` is updated at the edge where `por_n` rises. It becomes 1 if `boot_pins` were unchanged over the preceding SETUP_P×PRESCALE edges, and 0 otherwise. A change of `boot_pins` during the hold window later clears it.
- R4: `boot_window` is high from the rise of `por_n` for HOLD_P×PRESCALE cycles. It is low otherwise and never high while `por_n` is low.
- R5: One edge after the hold window closes, `boot_word` takes the `boot_pins` value sampled at that edge. `boot_valid` is high for exactly that one cycle. `boot_word` does not change at any other time.
- R6: `aon_rst_n` goes high once `aon_rails_ok` and `clk32k_ok` have both been sampled high on AON_MS milliseconds of edges plus one. The millisecond count is CLK_HZ/1000 cycles. It falls at the first edge where either flag is sampled low.
- R7: `periph_rst_n` goes high PERIPH_MS milliseconds plus one cycle after `por_n` rises.
- R8: `periph_rst_n` is never high while `por_n` is low.
- R9: A low `warm_rst_n` keeps `por_n` low, even when the supply and oscillator flags are good.
- R10: A drop of any qualifying flag during a delay restarts that delay from zero.
- R11: After `rst_n` is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer's own registers |
| rails_ok | input | 1 | All main supply rails stable |
| osc_ok | input | 1 | Main oscillator running at a valid frequency |
| aon_rails_ok | input | 1 | Always-on domain rails stable |
| clk32k_ok | input | 1 | 32 kHz clock valid |
| warm_rst_n | input | 1 | External warm reset request, active low |
| boot_pins | input | 16 | Boot strap pins |
| por_n | output | 1 | Main power-on reset, active low |
| aon_rst_n | output | 1 | Always-on domain reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low, gated by `por_n` |
| boot_window | output | 1 | Boot pins must be held during this window |
| boot_valid | output | 1 | One-cycle pulse when `boot_word` is loaded |
| boot_word | output | 16 | Latched boot strap word |
| boot_ok | output | 1 | Boot pins met the setup and hold windows |

## Verification
The assertions assume that all flags and boot pins are synchronous to `clk` and change only between edges. They also assume that `rst_n` is applied before any release is expected. The bench drives every input at the falling edge, so each value is steady when the next rising edge samples it. The random phases last from tens to hundreds of cycles. Some are shorter than the release delays, which exercises restart, and others are longer, which exercises release. Pin changes fall both inside and outside the setup and hold windows.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned BOOT_W = 16;

  function automatic int unsigned ms_to_cycles(input int unsigned clk_hz,
                                               input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction
endpackage

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
  parameter int unsigned UNIT  = 610,
  parameter int unsigned COUNT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(COUNT + 1);
  localparam int unsigned PW = (UNIT > 1) ? $clog2(UNIT) : 1;

  logic          tick;
  logic [CW-1:0] cnt_q, cnt_d;

  generate
    if (UNIT > 1) begin : g_prescale
      logic [PW-1:0] pre_q, pre_d;
      assign tick = run && (pre_q == PW'(UNIT - 1));
      always_comb begin
        if (!run || tick) pre_d = '0;
        else              pre_d = pre_q + PW'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end else begin : g_direct
      assign tick = run;
    end
  endgenerate

  always_comb begin
    if (!run)                                 cnt_d = '0;
    else if (tick && (cnt_q != CW'(COUNT)))   cnt_d = cnt_q + CW'(1);
    else                                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CW'(COUNT));
endmodule

// File: rtl/por_boot_latch.sv
module por_boot_latch
  import por_pkg::*;
#(
  parameter int unsigned PRESCALE = 610,
  parameter int unsigned SETUP_P  = 2,
  parameter int unsigned HOLD_P   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_q,
  input  logic              por_rise,
  input  logic [BOOT_W-1:0] boot_pins,
  output logic              boot_window,
  output logic              boot_valid,
  output logic [BOOT_W-1:0] boot_word,
  output logic              boot_ok
);
  logic [BOOT_W-1:0] pins_q;
  logic              pins_same;
  logic              setup_done;
  logic              hold_done;
  logic              captured_q, captured_d;
  logic              valid_q, valid_d;
  logic [BOOT_W-1:0] word_q, word_d;
  logic              ok_q, ok_d;
  logic              grab;

  assign pins_same = (boot_pins == pins_q);

  por_delay_timer #(.UNIT(PRESCALE), .COUNT(SETUP_P)) u_setup (
    .clk(clk), .rst_n(rst_n), .run(pins_same), .done(setup_done)
  );

  por_delay_timer #(.UNIT(PRESCALE), .COUNT(HOLD_P)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(por_q), .done(hold_done)
  );

  assign boot_window = por_q && !hold_done;
  assign grab        = por_q && hold_done && !captured_q;

  always_comb begin
    captured_d = por_q ? (captured_q || grab) : 1'b0;
    valid_d    = grab;
    word_d     = grab ? boot_pins : word_q;
    if (por_rise)                       ok_d = setup_done;
    else if (boot_window && !pins_same) ok_d = 1'b0;
    else                                ok_d = ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q     <= '0;
      captured_q <= 1'b0;
      valid_q    <= 1'b0;
      word_q     <= '0;
      ok_q       <= 1'b0;
    end else begin
      pins_q     <= boot_pins;
      captured_q <= captured_d;
      valid_q    <= valid_d;
      word_q     <= word_d;
      ok_q       <= ok_d;
    end
  end

  assign boot_valid = valid_q;
  assign boot_word  = word_q;
  assign boot_ok    = ok_q;
endmodule

// File: rtl/por_seq_ctrl.sv
module por_seq_ctrl
  import por_pkg::*;
#(
  parameter int unsigned PRESCALE  = 610,
  parameter int unsigned MAIN_P    = 12,
  parameter int unsigned SETUP_P   = 2,
  parameter int unsigned HOLD_P    = 15,
  parameter int unsigned CLK_HZ    = 20_000_000,
  parameter int unsigned AON_MS    = 1,
  parameter int unsigned PERIPH_MS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rails_ok,
  input  logic              osc_ok,
  input  logic              aon_rails_ok,
  input  logic              clk32k_ok,
  input  logic              warm_rst_n,
  input  logic [BOOT_W-1:0] boot_pins,
  output logic              por_n,
  output logic              aon_rst_n,
  output logic              periph_rst_n,
  output logic              boot_window,
  output logic              boot_valid,
  output logic [BOOT_W-1:0] boot_word,
  output logic              boot_ok
);
  localparam int unsigned AON_CYC    = ms_to_cycles(CLK_HZ, AON_MS);
  localparam int unsigned PERIPH_CYC = ms_to_cycles(CLK_HZ, PERIPH_MS);

  logic main_run, main_done;
  logic aon_run, aon_done;
  logic periph_done;
  logic por_q, por_d;
  logic aon_q, aon_d;
  logic periph_q, periph_d;
  logic por_rise;

  assign main_run = rails_ok && osc_ok && warm_rst_n;
  assign aon_run  = aon_rails_ok && clk32k_ok;

  por_delay_timer #(.UNIT(PRESCALE), .COUNT(MAIN_P)) u_main (
    .clk(clk), .rst_n(rst_n), .run(main_run), .done(main_done)
  );

  por_delay_timer #(.UNIT(1), .COUNT(AON_CYC)) u_aon (
    .clk(clk), .rst_n(rst_n), .run(aon_run), .done(aon_done)
  );

  por_delay_timer #(.UNIT(1), .COUNT(PERIPH_CYC)) u_periph (
    .clk(clk), .rst_n(rst_n), .run(por_q), .done(periph_done)
  );

  always_comb begin
    por_d    = main_run && main_done;
    aon_d    = aon_run && aon_done;
    periph_d = periph_done;
    por_rise = por_d && !por_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q    <= 1'b0;
      aon_q    <= 1'b0;
      periph_q <= 1'b0;
    end else begin
      por_q    <= por_d;
      aon_q    <= aon_d;
      periph_q <= periph_d;
    end
  end

  por_boot_latch #(.PRESCALE(PRESCALE), .SETUP_P(SETUP_P), .HOLD_P(HOLD_P)) u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_q      (por_q),
    .por_rise   (por_rise),
    .boot_pins  (boot_pins),
    .boot_window(boot_window),
    .boot_valid (boot_valid),
    .boot_word  (boot_word),
    .boot_ok    (boot_ok)
  );

  assign por_n        = por_q;
  assign aon_rst_n    = aon_q;
  assign periph_rst_n = periph_q && por_q;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rails_ok,
  input logic        osc_ok,
  input logic        aon_rails_ok,
  input logic        clk32k_ok,
  input logic        warm_rst_n,
  input logic        por_n,
  input logic        aon_rst_n,
  input logic        periph_rst_n,
  input logic        boot_window,
  input logic        boot_valid,
  input logic [15:0] boot_word
);
  p_main_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rails_ok && osc_ok) |=> !por_n);

  p_warm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst_n |=> !por_n);

  p_aon_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(aon_rails_ok && clk32k_ok) |=> !aon_rst_n);

  p_periph_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !por_n |-> !periph_rst_n);

  p_window_in_por_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_window |-> por_n);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    boot_valid |=> !boot_valid);

  p_word_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_valid |-> $stable(boot_word));
endmodule

bind por_seq_ctrl por_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rails_ok    (rails_ok),
  .osc_ok      (osc_ok),
  .aon_rails_ok(aon_rails_ok),
  .clk32k_ok   (clk32k_ok),
  .warm_rst_n  (warm_rst_n),
  .por_n       (por_n),
  .aon_rst_n   (aon_rst_n),
  .periph_rst_n(periph_rst_n),
  .boot_window (boot_window),
  .boot_valid  (boot_valid),
  .boot_word   (boot_word)
);

// File: tb/por_seq_ctrl_tb.sv
module por_seq_ctrl_tb;
  localparam int PS  = 8;
  localparam int MP  = 12;
  localparam int SP  = 2;
  localparam int HP  = 15;
  localparam int HZ  = 100_000;
  localparam int AMS = 1;
  localparam int PMS = 2;
  localparam int MAIN_C = MP * PS;
  localparam int SET_C  = SP * PS;
  localparam int HOLD_C = HP * PS;
  localparam int AON_C  = (HZ / 1000) * AMS;
  localparam int PER_C  = (HZ / 1000) * PMS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rails_ok = 1'b0, osc_ok = 1'b0, aon_rails_ok = 1'b0, clk32k_ok = 1'b0;
  logic warm_rst_n = 1'b0;
  logic [15:0] boot_pins = '0;
  logic por_n, aon_rst_n, periph_rst_n, boot_window, boot_valid, boot_ok;
  logic [15:0] boot_word;

  always #2 clk = ~clk;

  por_seq_ctrl #(.PRESCALE(PS), .MAIN_P(MP), .SETUP_P(SP), .HOLD_P(HP),
                 .CLK_HZ(HZ), .AON_MS(AMS), .PERIPH_MS(PMS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rails_ok(rails_ok), .osc_ok(osc_ok),
    .aon_rails_ok(aon_rails_ok), .clk32k_ok(clk32k_ok), .warm_rst_n(warm_rst_n),
    .boot_pins(boot_pins), .por_n(por_n), .aon_rst_n(aon_rst_n),
    .periph_rst_n(periph_rst_n), .boot_window(boot_window), .boot_valid(boot_valid),
    .boot_word(boot_word), .boot_ok(boot_ok)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 0;

  // reference state, updated from the requirements at each rising edge
  int  m_run, a_run, p_run, s_run;
  bit  e_por, e_aon, e_perq, e_valid, e_cap, e_ok;
  logic [15:0] e_word, e_prev;

  function automatic bit exp_window(input bit por, input int prun);
    return por && (prun < HOLD_C);
  endfunction

  function automatic int bump(input bit cond, input int v);
    if (!cond) return 0;
    return (v < 1_000_000) ? v + 1 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; a_run = 0; p_run = 0; s_run = 0;
      e_por = 0; e_aon = 0; e_perq = 0; e_valid = 0; e_cap = 0; e_ok = 0;
      e_word = '0; e_prev = '0;
    end else begin
      bit b_por, main_c, aon_c, stable, hold_dn, win_b, grab, new_por, set_dn;
      b_por   = e_por;
      main_c  = rails_ok && osc_ok && warm_rst_n;
      aon_c   = aon_rails_ok && clk32k_ok;
      new_por = main_c && (m_run >= MAIN_C);
      e_aon   = aon_c && (a_run >= AON_C);
      e_perq  = (p_run >= PER_C);
      hold_dn = (p_run >= HOLD_C);
      win_b   = b_por && !hold_dn;
      grab    = b_por && hold_dn && !e_cap;
      stable  = (boot_pins == e_prev);
      set_dn  = (s_run >= SET_C);
      e_valid = grab;
      if (grab) e_word = boot_pins;
      e_cap   = b_por ? (e_cap || grab) : 1'b0;
      if (new_por && !b_por)     e_ok = set_dn;
      else if (win_b && !stable) e_ok = 1'b0;
      m_run  = bump(main_c, m_run);
      a_run  = bump(aon_c, a_run);
      p_run  = bump(b_por, p_run);
      s_run  = bump(stable, s_run);
      e_prev = boot_pins;
      e_por  = new_por;
    end
  end

  task automatic chk(input bit got, input bit exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(por_n, e_por, "R1 por_n");
    chk(aon_rst_n, e_aon, "R6 aon_rst_n");
    chk(periph_rst_n, e_perq && e_por, "R7 periph_rst_n");
    chk(boot_window, exp_window(e_por, p_run), "R4 boot_window");
    chk(boot_valid, e_valid, "R5 boot_valid");
    chk(boot_ok, e_ok, "R3 boot_ok");
    n_checks++;
    if (boot_word !== e_word) begin
      n_fail++;
      $display("FAIL R5 boot_word got %h expected %h", boot_word, e_word);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic set_all(input bit v);
    rails_ok = v; osc_ok = v; aon_rails_ok = v; clk32k_ok = v; warm_rst_n = v;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200_000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(por_n, 1'b0, "R11 por_n reset");
    chk(aon_rst_n, 1'b0, "R11 aon reset");
    chk(periph_rst_n, 1'b0, "R11 periph reset");
    chk(boot_valid, 1'b0, "R11 valid reset");
    rst_n = 1'b1;
    step(2);

    // R1/R2 directed: exact release edge
    boot_pins = 16'hA5C3;
    set_all(1'b1);
    step(MAIN_C);
    chk(por_n, 1'b0, "R1 low one edge before release");
    chk(aon_rst_n, 1'b0, "R6 still held");
    step(1);
    chk(por_n, 1'b1, "R1 released after 12 units");
    step(HOLD_C + 2);
    chk(boot_ok, 1'b1, "R3 steady pins accepted");
    chk(boot_word == 16'hA5C3, 1'b1, "R5 word latched");
    step(PER_C);

    // R9: warm reset alone holds main reset
    warm_rst_n = 1'b0;
    step(1);
    chk(por_n, 1'b0, "R9 warm low drops por");
    chk(periph_rst_n, 1'b0, "R8 periph follows por");
    step(MAIN_C + 20);
    chk(por_n, 1'b0, "R9 warm low keeps por");

    // R10: glitch mid-count restarts
    warm_rst_n = 1'b1;
    step(MAIN_C - 10);
    osc_ok = 1'b0;
    step(1);
    osc_ok = 1'b1;
    step(MAIN_C - 5);
    chk(por_n, 1'b0, "R10 restart after glitch");
    step(10);
    chk(por_n, 1'b1, "R10 released after full delay");

    // R3: pin change just before release
    rails_ok = 1'b0;
    step(2);
    rails_ok = 1'b1;
    step(MAIN_C - PS);
    boot_pins = 16'h0F0F;
    step(PS + 1 + HOLD_C + 2);
    chk(boot_ok, 1'b0, "R3 late pin change flagged");

    // R3/R4: pin change inside hold window
    rails_ok = 1'b0;
    step(2);
    rails_ok = 1'b1;
    step(MAIN_C + 1 + 20);
    boot_pins = 16'h1234;
    step(HOLD_C);
    chk(boot_ok, 1'b0, "R3 hold violation flagged");

    // random phases
    for (int ph = 0; ph < 220; ph++) begin
      int len = 20 + int'($urandom_range(0, 380));
      int pc  = int'($urandom_range(0, len - 1));
      rails_ok     = ($urandom_range(0, 9) != 0);
      osc_ok       = ($urandom_range(0, 9) != 0);
      warm_rst_n   = ($urandom_range(0, 9) != 0);
      aon_rails_ok = ($urandom_range(0, 7) != 0);
      clk32k_ok    = ($urandom_range(0, 7) != 0);
      for (int c = 0; c < len; c++) begin
        if (c == pc && $urandom_range(0, 2) == 0) boot_pins = 16'($urandom);
        step(1);
      end
    end
    finish_run();
  end
endmodule